// File: doc/BRIEF.md
# Banked Interrupt Enable and Route Controller

This block is one 32-line bank placed in front of a main interrupt controller. It receives 32 level-sensitive request lines and combines them into three outputs: a CPU normal interrupt, a CPU fast interrupt and a coprocessor interrupt. Each line's bit position inside the bank is its global line number modulo 32.

Software controls the bank through a plain 32-bit register port with address, write strobe, write data and read data. The port holds separate CPU and coprocessor enable masks, and each mask has write-one-to-set and write-one-to-clear aliases, so a single line can be changed without a read-modify-write. A software force mask raises a line as pending even when its input is low, which is how an interrupt is re-triggered, and end-of-interrupt handling clears that mask again. Per-line class masks choose whether an enabled CPU line goes to the normal or the fast output.

The register port is a control path with no back-pressure. Every write is accepted in the cycle its strobe is high, and read data follows the address combinationally.

Top module: `irq_bank_router`

## Requirements
- R1: After reset, every enable, force and class bit is 0. All three outputs are low, and the stored registers read back as 0.
- R2: A write to CPU enable-set (0x24) or coprocessor enable-set (0x34) sets each enable bit whose data bit is 1. All other enable bits keep their value.
- R3: A write to CPU enable-clear (0x28) or coprocessor enable-clear (0x38) clears each enable bit whose data bit is 1. Writing all ones disables all 32 lines in a single access.
- R4: A 1 written to force-set (0x18) makes that line pending even when its input is low. A 1 written to force-clear (0x1C) removes the forced state.
- R5: The CPU class (0x2C) and coprocessor class (0x3C) registers are written directly and read back. A CPU class bit of 0 sends its line to the normal output, and a 1 sends it to the fast output.
- R6: The CPU normal output is the OR over all lines of (input | force) & cpu_enable & ~class. The CPU fast output is the same OR with class in place of ~class.
- R7: The coprocessor output is the OR over all lines of (input | force) & cop_enable. The coprocessor class register has no effect on this output.
- R8: Reads of 0x14, 0x20 and 0x30 return the force, CPU enable and coprocessor enable masks. Reads of every set or clear alias return 0. A read of 0x08 returns the fast-pending vector (input | force) & cpu_enable & class.
- R9: Unmapped addresses read as 0 and ignore writes. Writes to the status addresses 0x14, 0x20 and 0x30 are also ignored.
- R10: The outputs are registered. A change on an input line reaches the outputs at the next clock edge, and a register write reaches them at the edge after the one that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Level-sensitive request lines |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| cpu_irq_o | output | 1 | CPU normal interrupt |
| cpu_fiq_o | output | 1 | CPU fast interrupt |
| cop_irq_o | output | 1 | Coprocessor interrupt |

## Verification
A stuck or wrongly updated enable, force or class bit shows up at the three outputs two edges after the write that should have changed it. It can also be seen at once, combinationally, when the matching status address is read. Because the class and enable masks are combined per line, a bit that lands in the wrong position sends a line to the wrong output or to none at all. The vector walk catches this by setting a single input line and looking for it on one output only. A write that leaks through an alias or an unmapped address changes a status readback right away, and the outputs show it within two cycles.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned LINES = 32;
  localparam int unsigned AW    = 8;

  localparam logic [AW-1:0] A_FIQ_VIEW  = 8'h08;
  localparam logic [AW-1:0] A_FRC_STAT  = 8'h14;
  localparam logic [AW-1:0] A_FRC_SET   = 8'h18;
  localparam logic [AW-1:0] A_FRC_CLR   = 8'h1C;
  localparam logic [AW-1:0] A_CPU_EN    = 8'h20;
  localparam logic [AW-1:0] A_CPU_SET   = 8'h24;
  localparam logic [AW-1:0] A_CPU_CLR   = 8'h28;
  localparam logic [AW-1:0] A_CPU_CLASS = 8'h2C;
  localparam logic [AW-1:0] A_COP_EN    = 8'h30;
  localparam logic [AW-1:0] A_COP_SET   = 8'h34;
  localparam logic [AW-1:0] A_COP_CLR   = 8'h38;
  localparam logic [AW-1:0] A_COP_CLASS = 8'h3C;
endpackage

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] SET_ADDR = '0,
  parameter logic [AW-1:0] CLR_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  q
);
  logic do_set, do_clr;
  assign do_set = wr && (addr == SET_ADDR);
  assign do_clr = wr && (addr == CLR_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (do_set) q <= q | wdata;
    else if (do_clr) q <= q & ~wdata;
  end

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == SET_ADDR) |=> ((q & $past(wdata)) == $past(wdata)));
  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == CLR_ADDR) |=> ((q & $past(wdata)) == '0));
  assert_other_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && (addr == SET_ADDR || addr == CLR_ADDR))) |=> $stable(q));
endmodule

// File: rtl/irq_route_core.sv
module irq_route_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  input  logic [W-1:0] force_m,
  input  logic [W-1:0] cpu_en,
  input  logic [W-1:0] cpu_cls,
  input  logic [W-1:0] cop_en,
  output logic [W-1:0] fiq_view,
  output logic         cpu_irq,
  output logic         cpu_fiq,
  output logic         cop_irq
);
  logic [W-1:0] irq_hit, fiq_hit, cop_hit;

  for (genvar i = 0; i < W; i++) begin : g_line
    logic pend;
    assign pend       = lines[i] | force_m[i];
    assign irq_hit[i] = pend & cpu_en[i] & ~cpu_cls[i];
    assign fiq_hit[i] = pend & cpu_en[i] &  cpu_cls[i];
    assign cop_hit[i] = pend & cop_en[i];
  end

  assign fiq_view = fiq_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_irq <= 1'b0;
      cpu_fiq <= 1'b0;
      cop_irq <= 1'b0;
    end else begin
      cpu_irq <= |irq_hit;
      cpu_fiq <= |fiq_hit;
      cop_irq <= |cop_hit;
    end
  end

  assert_cpu_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en == '0) |=> (!cpu_irq && !cpu_fiq));
  assert_cop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_en == '0) |=> !cop_irq);
  assert_irq_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_cls == {W{1'b1}}) |=> !cpu_irq);
endmodule

// File: rtl/irq_bank_router.sv
module irq_bank_router
  import irq_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_lines,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [LINES-1:0] reg_wdata,
  output logic [LINES-1:0] reg_rdata,
  output logic             cpu_irq_o,
  output logic             cpu_fiq_o,
  output logic             cop_irq_o
);
  logic [LINES-1:0] force_m, cpu_en, cop_en, fiq_view;
  logic [LINES-1:0] cpu_cls, cop_cls;

  irq_setclr_reg #(.W(LINES), .AW(AW), .SET_ADDR(A_FRC_SET), .CLR_ADDR(A_FRC_CLR)) u_force (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .q(force_m));
  irq_setclr_reg #(.W(LINES), .AW(AW), .SET_ADDR(A_CPU_SET), .CLR_ADDR(A_CPU_CLR)) u_cpu_en (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .q(cpu_en));
  irq_setclr_reg #(.W(LINES), .AW(AW), .SET_ADDR(A_COP_SET), .CLR_ADDR(A_COP_CLR)) u_cop_en (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .q(cop_en));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_cls <= '0;
      cop_cls <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CPU_CLASS) cpu_cls <= reg_wdata;
      if (reg_addr == A_COP_CLASS) cop_cls <= reg_wdata;
    end
  end

  irq_route_core #(.W(LINES)) u_route (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines), .force_m(force_m),
    .cpu_en(cpu_en), .cpu_cls(cpu_cls), .cop_en(cop_en), .fiq_view(fiq_view),
    .cpu_irq(cpu_irq_o), .cpu_fiq(cpu_fiq_o), .cop_irq(cop_irq_o));

  always_comb begin
    case (reg_addr)
      A_FIQ_VIEW:  reg_rdata = fiq_view;
      A_FRC_STAT:  reg_rdata = force_m;
      A_CPU_EN:    reg_rdata = cpu_en;
      A_CPU_CLASS: reg_rdata = cpu_cls;
      A_COP_EN:    reg_rdata = cop_en;
      A_COP_CLASS: reg_rdata = cop_cls;
      default:     reg_rdata = '0;
    endcase
  end

  assert_cpu_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CPU_CLASS) |=> (cpu_cls == $past(reg_wdata)));
  assert_cop_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_COP_CLASS) |=> (cop_cls == $past(reg_wdata)));
  assert_class_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr) |=> ($stable(cpu_cls) && $stable(cop_cls)));
endmodule

// File: tb/irq_bank_router_bench.sv
module irq_bank_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq_o, cpu_fiq_o, cop_irq_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_bank_router u_irq_bank_router (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq_o(cpu_irq_o), .cpu_fiq_o(cpu_fiq_o), .cop_irq_o(cop_irq_o));

  // {write addr, write data, input lines, expected {irq, fiq, cop}}
  localparam logic [74:0] VEC [12] = '{
    {8'h24, 32'h0000_0001, 32'h0000_0000, 3'b000}, // R2 enable with no input
    {8'h00, 32'hFFFF_FFFF, 32'h0000_0001, 3'b100}, // R9 unmapped write, R6 irq route
    {8'h2C, 32'h0000_0001, 32'h0000_0001, 3'b010}, // R5 class to fast output
    {8'h34, 32'h8000_0000, 32'h8000_0000, 3'b001}, // R2 cop enable line 31
    {8'h3C, 32'hFFFF_FFFF, 32'h8000_0000, 3'b001}, // R7 cop class ignored
    {8'h18, 32'h0000_0002, 32'h0000_0000, 3'b000}, // R4 force on disabled line
    {8'h24, 32'h0000_0002, 32'h0000_0000, 3'b100}, // R4 forced line with input low
    {8'h1C, 32'h0000_0002, 32'h0000_0000, 3'b000}, // R4 force cleared
    {8'h20, 32'h0000_0000, 32'h0000_0003, 3'b110}, // R9 status write ignored, R6 both
    {8'h28, 32'hFFFF_FFFF, 32'h0000_0003, 3'b000}, // R3 clear all
    {8'h30, 32'h0000_0000, 32'hFFFF_FFFF, 3'b001}, // R9 status write ignored
    {8'h38, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000}  // R3 cop clear all
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs", {29'd0, cpu_irq_o, cpu_fiq_o, cop_irq_o}, 32'd0);
    rd("R1 cpu enable", 8'h20, 32'd0);
    rd("R1 force", 8'h14, 32'd0);
    rd("R1 cpu class", 8'h2C, 32'd0);
    rd("R1 cop enable", 8'h30, 32'd0);

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      reg_addr  = VEC[i][74:67];
      reg_wdata = VEC[i][66:35];
      irq_lines = VEC[i][34:3];
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      @(negedge clk);
      chk($sformatf("R6/R7 vector %0d", i), {29'd0, cpu_irq_o, cpu_fiq_o, cop_irq_o},
          {29'd0, VEC[i][2:0]});
    end

    // end state: enables 0, force 0, cpu class 1, cop class all ones
    rd("R5 cpu class readback", 8'h2C, 32'h0000_0001);
    rd("R5 cop class readback", 8'h3C, 32'hFFFF_FFFF);
    rd("R8 set alias reads 0", 8'h24, 32'd0);
    wr(8'h24, 32'h0000_0005);
    rd("R8 cpu enable status", 8'h20, 32'h0000_0005);
    rd("R8 clear alias reads 0", 8'h28, 32'd0);
    wr(8'h18, 32'h0000_0004);
    rd("R8 force status", 8'h14, 32'h0000_0004);
    irq_lines = 32'h0000_0001;
    rd("R8 fast pending view", 8'h08, 32'h0000_0001);
    rd("R9 unmapped read", 8'h40, 32'd0);
    wr(8'h1C, 32'h0000_0004);
    rd("R4 force clear status", 8'h14, 32'd0);

    // R10 timing: input change reaches output at next edge
    irq_lines = 32'd0;
    @(negedge clk); @(negedge clk);
    irq_lines = 32'h0000_0001;
    #1 chk("R10 before edge", {31'd0, cpu_fiq_o}, 32'd0);
    @(negedge clk);
    chk("R10 after one edge", {31'd0, cpu_fiq_o}, 32'd1);
    // R3 single-bit clear leaves others
    wr(8'h28, 32'h0000_0001);
    rd("R3 partial clear", 8'h20, 32'h0000_0004);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule